// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns an inter-processor interrupt command into a per-agent delivery bitmask for a system of `N_AGENTS` local interrupt controllers. Each agent presents three values. The first is its 8-bit ID. The second is its 8-bit logical address register. The third is its 4-bit destination format, which selects flat or cluster matching.

The command is written as two 32-bit words through one write-data bus. The high word holds the destination byte. The low word holds the vector, delivery mode, destination-mode bit, level and trigger bits, and a shorthand code. Writing the high word only stores it. Writing the low word starts resolution against the stored destination and the sender's own index.

One clock later the block presents a registered target mask with the vector, mode and trigger, together with a one-cycle delivery strobe. For the INIT level-deassert command it does not deliver. Instead it raises a separate strobe that tells the targeted agents to copy their ID into their arbitration ID. Injecting the interrupt into the targets is left to the logic that consumes the strobe.

Top module: `irq_dest_resolver`

## Requirements
- R1: In the cycle after synchronous reset, `dlv_valid`, `arb_sync_valid`, `dlv_mask`, `arb_sync_mask`, `dlv_vector`, `dlv_mode` and `dlv_trigger` are all zero.
- R2: The command fields are placed as follows.
  - High word: the destination byte is bits [31:24].
  - Low word: vector [7:0], delivery mode [10:8], logical-mode bit 11, level bit 14, trigger bit 15, shorthand [19:18].

  A high-word write alone produces no strobe. A low-word write raises `dlv_valid` for exactly one cycle, in the cycle after the write, with vector, mode and trigger copied from those fields.
- R3: With shorthand 0 and physical mode (bit 11 = 0), destination 0xFF selects every agent.
- R4: With shorthand 0 and physical mode, any other destination selects only the lowest-indexed agent whose ID equals it. If no agent matches, the mask is empty and the strobe still pulses.
- R5: With shorthand 0 and logical mode, an agent with format 0xF (flat) is selected when the destination AND its logical register is nonzero.
- R6: With shorthand 0 and logical mode, an agent with format 0x0 (cluster) is selected when the upper nibbles of the destination and its logical register are equal and the lower nibbles share a set bit. Agents with any other format are never selected.
- R7: Shorthand 1 selects only the sender, whatever the destination byte and mode bit.
- R8: Shorthand 2 selects every agent. Shorthand 3 selects every agent except the sender.
- R9: Delivery mode 1 (lowest priority) reduces the resolved mask to its lowest-indexed set bit.
- R10: Delivery mode 5 (INIT) with level 0 and trigger 1 raises no `dlv_valid`. Instead, `arb_sync_valid` pulses for one cycle with the resolved mask on `arb_sync_mask`. INIT with any other level/trigger pair is delivered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_hi | input | 1 | Write strobe for the high command word |
| cmd_wr_lo | input | 1 | Write strobe for the low command word; starts resolution |
| cmd_wdata | input | 32 | Command write data |
| sender_idx | input | IDX_W | Index of the agent issuing the command |
| agent_id_vec | input | N_AGENTS*ID_W | Packed per-agent IDs, agent i at [i*ID_W +: ID_W] |
| agent_ldr_vec | input | N_AGENTS*ID_W | Packed per-agent logical address registers |
| agent_fmt_vec | input | N_AGENTS*FMT_W | Packed per-agent destination formats |
| dlv_valid | output | 1 | One-cycle delivery strobe |
| dlv_mask | output | N_AGENTS | Resolved delivery targets |
| dlv_vector | output | 8 | Vector of the delivered command |
| dlv_mode | output | 3 | Delivery mode of the delivered command |
| dlv_trigger | output | 1 | Trigger bit of the delivered command |
| arb_sync_valid | output | 1 | One-cycle strobe for arbitration-ID reload |
| arb_sync_mask | output | N_AGENTS | Agents that reload their arbitration ID |

## Verification
The bench builds the block with its defaults: eight agents, 8-bit IDs and 4-bit formats. With these values a single fixed agent table covers every matching path. Two agents share one ID, which exposes the lowest-index tie-break in physical mode. Flat and cluster agents sit side by side, and one agent has an unsupported format that must never match. Eight agents also make the all-but-self shorthand and the lowest-priority reduction distinguishable from full broadcast with every sender index used.

// File: rtl/irqdr_pkg.sv
package irqdr_pkg;
  // Low command word field positions
  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int LOGIC_BIT = 11;
  localparam int LEVEL_BIT = 14;
  localparam int TRIG_BIT  = 15;
  localparam int SH_LSB    = 18;
  // High command word destination top bit
  localparam int DEST_MSB  = 31;

  localparam logic [2:0] DM_LOWPRI = 3'd1;
  localparam logic [2:0] DM_INIT   = 3'd5;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;
endpackage

// File: rtl/irqdr_agent_match.sv
module irqdr_agent_match #(
  parameter int ID_W  = 8,
  parameter int FMT_W = 4
) (
  input  logic [ID_W-1:0]  dest,
  input  logic [ID_W-1:0]  agent_id,
  input  logic [ID_W-1:0]  agent_ldr,
  input  logic [FMT_W-1:0] agent_fmt,
  output logic             phys_hit,
  output logic             log_hit
);
  localparam int HALF = ID_W / 2;

  logic flat_hit;
  logic clus_hit;

  assign phys_hit = (dest == agent_id);
  assign flat_hit = |(dest & agent_ldr);
  assign clus_hit = (dest[ID_W-1:HALF] == agent_ldr[ID_W-1:HALF]) &&
                    (|(dest[HALF-1:0] & agent_ldr[HALF-1:0]));

  always_comb begin
    if (agent_fmt == {FMT_W{1'b1}})  log_hit = flat_hit;
    else if (agent_fmt == '0)        log_hit = clus_hit;
    else                             log_hit = 1'b0;
  end
endmodule

// File: rtl/irqdr_first_one.sv
module irqdr_first_one #(
  parameter int W = 8
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] pick
);
  logic found;
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (req[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqdr_target_sel.sv
module irqdr_target_sel
  import irqdr_pkg::*;
#(
  parameter int N_AGENTS = 8,
  parameter int IDX_W    = 3,
  parameter int ID_W     = 8
) (
  input  logic [ID_W-1:0]     dest,
  input  logic                logical,
  input  shorthand_e          shorthand,
  input  logic [IDX_W-1:0]    sender_idx,
  input  logic [N_AGENTS-1:0] phys_hit,
  input  logic [N_AGENTS-1:0] log_hit,
  output logic [N_AGENTS-1:0] mask
);
  logic [N_AGENTS-1:0] phys_first;
  logic [N_AGENTS-1:0] self_bit;
  logic [N_AGENTS-1:0] addr_mask;

  irqdr_first_one #(.W(N_AGENTS)) u_phys_first (
    .req  (phys_hit),
    .pick (phys_first)
  );

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_self
    assign self_bit[g] = (sender_idx == IDX_W'(g));
  end

  always_comb begin
    if (logical)                   addr_mask = log_hit;
    else if (dest == {ID_W{1'b1}}) addr_mask = '1;
    else                           addr_mask = phys_first;
  end

  always_comb begin
    unique case (shorthand)
      SH_SELF:   mask = self_bit;
      SH_ALL:    mask = '1;
      SH_OTHERS: mask = ~self_bit;
      default:   mask = addr_mask;
    endcase
  end
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irqdr_pkg::*;
#(
  parameter int N_AGENTS = 8,
  parameter int ID_W     = 8,
  parameter int FMT_W    = 4,
  localparam int IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_wr_hi,
  input  logic                      cmd_wr_lo,
  input  logic [31:0]               cmd_wdata,
  input  logic [IDX_W-1:0]          sender_idx,
  input  logic [N_AGENTS*ID_W-1:0]  agent_id_vec,
  input  logic [N_AGENTS*ID_W-1:0]  agent_ldr_vec,
  input  logic [N_AGENTS*FMT_W-1:0] agent_fmt_vec,
  output logic                      dlv_valid,
  output logic [N_AGENTS-1:0]       dlv_mask,
  output logic [7:0]                dlv_vector,
  output logic [2:0]                dlv_mode,
  output logic                      dlv_trigger,
  output logic                      arb_sync_valid,
  output logic [N_AGENTS-1:0]       arb_sync_mask
);
  logic [ID_W-1:0]     dest_q;
  logic [N_AGENTS-1:0] phys_hit;
  logic [N_AGENTS-1:0] log_hit;
  logic [N_AGENTS-1:0] resolved;
  logic [N_AGENTS-1:0] lowest;
  logic [N_AGENTS-1:0] final_mask;
  logic [2:0]          mode;
  logic                init_deassert;
  logic                unused_rsvd;

  assign unused_rsvd = ^{cmd_wdata[31-ID_W:20], cmd_wdata[17:16], cmd_wdata[13:12]};

  // High word: only the destination byte is kept
  always_ff @(posedge clk) begin
    if (rst)            dest_q <= '0;
    else if (cmd_wr_hi) dest_q <= cmd_wdata[DEST_MSB -: ID_W];
  end

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    irqdr_agent_match #(.ID_W(ID_W), .FMT_W(FMT_W)) u_match (
      .dest      (dest_q),
      .agent_id  (agent_id_vec[g*ID_W +: ID_W]),
      .agent_ldr (agent_ldr_vec[g*ID_W +: ID_W]),
      .agent_fmt (agent_fmt_vec[g*FMT_W +: FMT_W]),
      .phys_hit  (phys_hit[g]),
      .log_hit   (log_hit[g])
    );
  end

  irqdr_target_sel #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W), .ID_W(ID_W)) u_sel (
    .dest       (dest_q),
    .logical    (cmd_wdata[LOGIC_BIT]),
    .shorthand  (shorthand_e'(cmd_wdata[SH_LSB +: 2])),
    .sender_idx (sender_idx),
    .phys_hit   (phys_hit),
    .log_hit    (log_hit),
    .mask       (resolved)
  );

  irqdr_first_one #(.W(N_AGENTS)) u_lowpri (
    .req  (resolved),
    .pick (lowest)
  );

  assign mode          = cmd_wdata[MODE_LSB +: 3];
  assign init_deassert = (mode == DM_INIT) && !cmd_wdata[LEVEL_BIT] && cmd_wdata[TRIG_BIT];
  assign final_mask    = (mode == DM_LOWPRI) ? lowest : resolved;

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid      <= 1'b0;
      arb_sync_valid <= 1'b0;
      dlv_mask       <= '0;
      arb_sync_mask  <= '0;
      dlv_vector     <= '0;
      dlv_mode       <= '0;
      dlv_trigger    <= 1'b0;
    end else begin
      dlv_valid      <= cmd_wr_lo && !init_deassert;
      arb_sync_valid <= cmd_wr_lo && init_deassert;
      if (cmd_wr_lo) begin
        dlv_mask      <= final_mask;
        arb_sync_mask <= resolved;
        dlv_vector    <= cmd_wdata[VEC_LSB +: 8];
        dlv_mode      <= mode;
        dlv_trigger   <= cmd_wdata[TRIG_BIT];
      end
    end
  end
endmodule

// File: rtl/irqdr_checker.sv
module irqdr_checker
  import irqdr_pkg::*;
#(
  parameter int N_AGENTS = 8,
  parameter int IDX_W    = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_wr_hi,
  input logic                cmd_wr_lo,
  input logic [31:0]         cmd_wdata,
  input logic [IDX_W-1:0]    sender_idx,
  input logic                dlv_valid,
  input logic [N_AGENTS-1:0] dlv_mask,
  input logic [2:0]          dlv_mode,
  input logic                arb_sync_valid
);
  logic is_init_off;
  logic is_lowpri;
  logic [1:0] sh;

  assign is_init_off = (cmd_wdata[MODE_LSB +: 3] == DM_INIT) &&
                       !cmd_wdata[LEVEL_BIT] && cmd_wdata[TRIG_BIT];
  assign is_lowpri   = (cmd_wdata[MODE_LSB +: 3] == DM_LOWPRI);
  assign sh          = cmd_wdata[SH_LSB +: 2];

  assert_strobe_src_R2: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid || arb_sync_valid) |-> $past(cmd_wr_lo));

  assert_hi_only_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr_hi && !cmd_wr_lo) |=> (!dlv_valid && !arb_sync_valid));

  assert_self_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr_lo && sh == 2'd1 && !is_init_off) |=>
      (dlv_valid && dlv_mask == (N_AGENTS'(1) << $past(sender_idx))));

  assert_others_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr_lo && sh == 2'd3 && !is_init_off && !is_lowpri) |=>
      (dlv_mask == ~(N_AGENTS'(1) << $past(sender_idx))));

  assert_lowpri_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && dlv_mode == DM_LOWPRI) |-> $onehot0(dlv_mask));

  assert_init_off_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr_lo && is_init_off) |=> (arb_sync_valid && !dlv_valid));
endmodule

bind irq_dest_resolver irqdr_checker #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cmd_wr_hi      (cmd_wr_hi),
  .cmd_wr_lo      (cmd_wr_lo),
  .cmd_wdata      (cmd_wdata),
  .sender_idx     (sender_idx),
  .dlv_valid      (dlv_valid),
  .dlv_mask       (dlv_mask),
  .dlv_mode       (dlv_mode),
  .arb_sync_valid (arb_sync_valid)
);

// File: tb/irq_dest_resolver_tb.sv
module irq_dest_resolver_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_wr_hi = 1'b0;
  logic         cmd_wr_lo = 1'b0;
  logic [31:0]  cmd_wdata = '0;
  logic [2:0]   sender_idx = '0;
  logic [N*8-1:0] agent_id_vec;
  logic [N*8-1:0] agent_ldr_vec;
  logic [N*4-1:0] agent_fmt_vec;
  logic         dlv_valid, dlv_trigger, arb_sync_valid;
  logic [N-1:0] dlv_mask, arb_sync_mask;
  logic [7:0]   dlv_vector;
  logic [2:0]   dlv_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_dest_resolver u_dut (
    .clk(clk), .rst(rst), .cmd_wr_hi(cmd_wr_hi), .cmd_wr_lo(cmd_wr_lo),
    .cmd_wdata(cmd_wdata), .sender_idx(sender_idx),
    .agent_id_vec(agent_id_vec), .agent_ldr_vec(agent_ldr_vec),
    .agent_fmt_vec(agent_fmt_vec),
    .dlv_valid(dlv_valid), .dlv_mask(dlv_mask), .dlv_vector(dlv_vector),
    .dlv_mode(dlv_mode), .dlv_trigger(dlv_trigger),
    .arb_sync_valid(arb_sync_valid), .arb_sync_mask(arb_sync_mask)
  );

  // Agent table: IDs 0x20+i except agent 6 duplicates 0x22.
  // Formats: 0-3 flat, 4-6 cluster, 7 unsupported (0x3).
  initial begin
    for (int i = 0; i < N; i++) agent_id_vec[i*8 +: 8] = 8'h20 + 8'(i);
    agent_id_vec[6*8 +: 8] = 8'h22;
    agent_ldr_vec = {8'h31, 8'h43, 8'h32, 8'h31, 8'h88, 8'h04, 8'h02, 8'h01};
    agent_fmt_vec = {4'h3, 4'h0, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF, 4'hF};
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lo_word(logic [7:0] vec, logic [2:0] mode,
      logic lgc, logic lvl, logic trg, logic [1:0] sh);
    return {12'h0, sh, 2'b00, trg, lvl, 2'b00, lgc, mode, vec};
  endfunction

  // Writes high then low word; returns at the negedge after the result edge.
  task automatic send(logic [7:0] dest, logic [31:0] lo, logic [2:0] snd);
    @(negedge clk);
    cmd_wr_hi = 1'b1; cmd_wdata = {dest, 24'h0};
    @(negedge clk);
    cmd_wr_hi = 1'b0;
    chk("R2", "no strobe after high write", {30'd0, dlv_valid, arb_sync_valid}, 32'd0);
    cmd_wr_lo = 1'b1; cmd_wdata = lo; sender_idx = snd;
    @(negedge clk);
    cmd_wr_lo = 1'b0; cmd_wdata = '0;
  endtask

  task automatic expect_dlv(string req, logic [7:0] exp_mask);
    chk(req, "dlv_valid", {31'd0, dlv_valid}, 32'd1);
    chk(req, "dlv_mask", {24'd0, dlv_mask}, {24'd0, exp_mask});
  endtask

  task automatic t_reset();
    chk("R1", "valids", {30'd0, dlv_valid, arb_sync_valid}, 32'd0);
    chk("R1", "masks", {16'd0, dlv_mask, arb_sync_mask}, 32'd0);
    chk("R1", "fields", {20'd0, dlv_vector, dlv_mode, dlv_trigger}, 32'd0);
  endtask

  task automatic t_fields_r2();
    send(8'hFF, lo_word(8'h5A, 3'd0, 1'b0, 1'b1, 1'b1, 2'd0), 3'd0);
    chk("R2", "vector", {24'd0, dlv_vector}, 32'h5A);
    chk("R2", "mode", {29'd0, dlv_mode}, 32'd0);
    chk("R2", "trigger", {31'd0, dlv_trigger}, 32'd1);
    chk("R2", "valid", {31'd0, dlv_valid}, 32'd1);
    @(negedge clk);
    chk("R2", "strobe one cycle", {31'd0, dlv_valid}, 32'd0);
    send(8'h20, lo_word(8'hC3, 3'd6, 1'b0, 1'b0, 1'b0, 2'd0), 3'd0);
    chk("R2", "vector 2", {24'd0, dlv_vector}, 32'hC3);
    chk("R2", "mode 2", {29'd0, dlv_mode}, 32'd6);
    chk("R2", "trigger 2", {31'd0, dlv_trigger}, 32'd0);
  endtask

  task automatic t_physical();
    send(8'hFF, lo_word(8'h40, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), 3'd2);
    expect_dlv("R3", 8'hFF);
    send(8'h22, lo_word(8'h41, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), 3'd0);
    expect_dlv("R4", 8'h04);
    send(8'h27, lo_word(8'h41, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), 3'd0);
    expect_dlv("R4", 8'h80);
    send(8'h99, lo_word(8'h42, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), 3'd0);
    expect_dlv("R4", 8'h00);
  endtask

  task automatic t_logical();
    send(8'h06, lo_word(8'h50, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0), 3'd0);
    expect_dlv("R5", 8'h06);
    send(8'h42, lo_word(8'h51, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0), 3'd0);
    expect_dlv("R6", 8'h42);
    send(8'h33, lo_word(8'h52, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0), 3'd0);
    expect_dlv("R6", 8'h33);
  endtask

  task automatic t_shorthand();
    send(8'hFF, lo_word(8'h60, 3'd0, 1'b0, 1'b0, 1'b0, 2'd1), 3'd3);
    expect_dlv("R7", 8'h08);
    send(8'h42, lo_word(8'h61, 3'd0, 1'b1, 1'b0, 1'b0, 2'd1), 3'd7);
    expect_dlv("R7", 8'h80);
    send(8'h99, lo_word(8'h62, 3'd0, 1'b0, 1'b0, 1'b0, 2'd2), 3'd4);
    expect_dlv("R8", 8'hFF);
    send(8'h20, lo_word(8'h63, 3'd0, 1'b0, 1'b0, 1'b0, 2'd3), 3'd0);
    expect_dlv("R8", 8'hFE);
    send(8'h20, lo_word(8'h63, 3'd0, 1'b0, 1'b0, 1'b0, 2'd3), 3'd5);
    expect_dlv("R8", 8'hDF);
  endtask

  task automatic t_lowpri();
    send(8'hFF, lo_word(8'h70, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0), 3'd0);
    expect_dlv("R9", 8'h01);
    send(8'h42, lo_word(8'h71, 3'd1, 1'b1, 1'b0, 1'b0, 2'd0), 3'd0);
    expect_dlv("R9", 8'h02);
    send(8'h20, lo_word(8'h72, 3'd1, 1'b0, 1'b0, 1'b0, 2'd3), 3'd0);
    expect_dlv("R9", 8'h02);
  endtask

  task automatic t_init();
    send(8'h00, lo_word(8'h00, 3'd5, 1'b0, 1'b0, 1'b1, 2'd2), 3'd0);
    chk("R10", "no delivery", {31'd0, dlv_valid}, 32'd0);
    chk("R10", "arb strobe", {31'd0, arb_sync_valid}, 32'd1);
    chk("R10", "arb mask", {24'd0, arb_sync_mask}, 32'hFF);
    @(negedge clk);
    chk("R10", "arb strobe one cycle", {31'd0, arb_sync_valid}, 32'd0);
    send(8'h00, lo_word(8'h00, 3'd5, 1'b0, 1'b0, 1'b1, 2'd3), 3'd2);
    chk("R10", "arb mask others", {24'd0, arb_sync_mask}, 32'hFB);
    send(8'h23, lo_word(8'h00, 3'd5, 1'b0, 1'b1, 1'b1, 2'd0), 3'd0);
    expect_dlv("R10", 8'h08);
    chk("R10", "no arb on assert", {31'd0, arb_sync_valid}, 32'd0);
    chk("R10", "mode init", {29'd0, dlv_mode}, 32'd5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fields_r2();
    t_physical();
    t_logical();
    t_shorthand();
    t_lowpri();
    t_init();
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule